// File: doc/BRIEF.md
# Smart-Card UART Transmitter

This block sends bytes over a single-wire asynchronous serial link of the kind used by smart cards. On that link the transmit and receive pins share one conductor. Software writes a byte into a one-entry holding buffer. When the shift stage is free and transmission is enabled, the byte moves into the shift stage. The shift stage sends a frame of eleven bits: a low start bit, eight data bits least significant first, a parity bit and a high stop bit. The bit time comes from a programmable prescale value applied to the block clock.

The shared conductor is fed back into the block. In the middle of its own stop bit the transmitter samples that conductor. If it sees a low level there, the far end is pulling the line low to reject the character, and a sticky error flag is latched. Two status outputs report whether the holding buffer is free and whether the whole transmitter has drained. A sticky interrupt request can be tied either to the buffer emptying or to the end of a frame. Deciding whether to resend a rejected character is left to software.

Top module: `scard_tx`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `txd` is 1, `buf_empty` is 1, `shift_empty` is 1, `irq` is 0 and `perr` is 0.
- R2: A frame is 11 bits, in this order: start bit (0), data bits 0 to 7 with bit 0 first, parity bit, stop bit (1). Each bit lasts exactly 16 × (`div_n` + 1) clock cycles.
- R3: The parity bit is the XOR of the eight data bits when `parity_odd` is 0 (even parity), and the inverse of that XOR when `parity_odd` is 1 (odd parity). `parity_odd` is taken at the moment the byte enters the shift stage.
- R4: A write (`wr_valid` high for one clock edge) is accepted only while `buf_empty` is 1, and `buf_empty` reads 0 in the following cycle. A write while `buf_empty` is 0 is dropped and does not change the held byte. `buf_empty` returns to 1 at the edge where the byte enters the shift stage, which is the same edge where `txd` drops for the start bit.
- R5: `shift_empty` is 1 only when no frame is in progress and the holding buffer is empty. `txd` is low only while `shift_empty` is 0.
- R6: While `tx_en` is 0, no new frame starts, `txd` stays 1 and a held byte is kept. Once `tx_en` returns to 1, that byte is sent.
- R7: With `irq_on_done` at 0, `irq` is set at the edge where the holding buffer hands its byte to the shift stage, and is not set at the end of a frame.
- R8: With `irq_on_done` at 1, `irq` is not set when the byte enters the shift stage. It is set at the edge that ends the stop bit.
- R9: `irq` stays set until a cycle with `irq_clr` high clears it. A set event in the same cycle as the clear wins.
- R10: `line_in` is sampled once per frame, at the edge 8 × (`div_n` + 1) cycles into the stop bit, and a 0 there sets `perr`. A low level on `line_in` during any other bit of the frame has no effect on `perr`.
- R11: `perr` stays set until a cycle with `err_clr` high clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the prescaler count source |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Allows new frames to start |
| parity_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| irq_on_done | input | 1 | Interrupt cause: 0 = buffer emptied, 1 = frame finished |
| div_n | input | DIV_W | Prescale value n; bit time is 16 × (n + 1) cycles |
| wr_valid | input | 1 | Writes `wr_data` into the holding buffer |
| wr_data | input | 8 | Byte to send |
| line_in | input | 1 | Level sensed on the shared conductor |
| irq_clr | input | 1 | Clears the interrupt request |
| err_clr | input | 1 | Write-one clear of the peer error flag |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can accept a byte |
| shift_empty | output | 1 | Nothing in progress and nothing pending |
| irq | output | 1 | Sticky transmit interrupt request |
| perr | output | 1 | Sticky flag: low level seen in the middle of the stop bit |

## Verification
The bench builds the block with a 4-bit prescale port and the default 16 sub-ticks per bit. It then drives `div_n` at 0, 1 and 2, so one frame takes only a few hundred cycles while bit lengths are still checked against three different multipliers. The bench models the shared wire as the AND of `txd` with a peer pull-down it controls. This allows it to pull the line low inside the stop-bit sampling window and, separately, in the middle of a data bit. It can therefore show both that the error flag is latched and that lows outside the window are ignored.

// File: rtl/scard_tx_pkg.sv
package scard_tx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
    } tx_frame_t;

    // Even parity is the XOR of the data; odd parity inverts it.
    function automatic logic frame_parity(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/scard_prescale.sv
module scard_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_n);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scard_shifter.sv
module scard_shifter
    import scard_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  tx_frame_t frame_in,
    input  logic      tick,
    input  logic      line_in,
    output logic      txd,
    output logic      busy,
    output logic      done,
    output logic      stop_low
);
    localparam int OS_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [OS_W-1:0]  OS_LAST  = OS_W'(OVS - 1);
    localparam logic [OS_W-1:0]  OS_MID   = OS_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] IDX_LAST = BIT_W'(DATA_W - 1);

    tx_state_e         state_q;
    logic [OS_W-1:0]   os_q;
    logic [BIT_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    logic              txd_q;

    assign txd      = txd_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_STOP) && tick && (os_q == OS_LAST);
    assign stop_low = (state_q == ST_STOP) && tick && (os_q == OS_MID) && !line_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            os_q    <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            txd_q   <= 1'b1;
        end else if (state_q == ST_IDLE) begin
            if (load) begin
                state_q <= ST_START;
                os_q    <= '0;
                idx_q   <= '0;
                sh_q    <= frame_in.data;
                par_q   <= frame_in.par;
                txd_q   <= 1'b0;
            end
        end else if (tick) begin
            if (os_q != OS_LAST) begin
                os_q <= os_q + 1'b1;
            end else begin
                os_q <= '0;
                case (state_q)
                    ST_START: begin
                        state_q <= ST_DATA;
                        txd_q   <= sh_q[0];
                        sh_q    <= sh_q >> 1;
                    end
                    ST_DATA: begin
                        if (idx_q == IDX_LAST) begin
                            state_q <= ST_PAR;
                            txd_q   <= par_q;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            txd_q <= sh_q[0];
                            sh_q  <= sh_q >> 1;
                        end
                    end
                    ST_PAR: begin
                        state_q <= ST_STOP;
                        txd_q   <= 1'b1;
                    end
                    default: begin
                        state_q <= ST_IDLE;
                        txd_q   <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/scard_flags.sv
module scard_flags (
    input  logic clk,
    input  logic rst,
    input  logic irq_on_done,
    input  logic load,
    input  logic done,
    input  logic stop_low,
    input  logic irq_clr,
    input  logic err_clr,
    output logic irq,
    output logic perr
);
    logic irq_q;
    logic perr_q;
    logic irq_set;

    assign irq_set = irq_on_done ? done : load;
    assign irq     = irq_q;
    assign perr    = perr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (irq_set) begin
                irq_q <= 1'b1;
            end else if (irq_clr) begin
                irq_q <= 1'b0;
            end
            if (stop_low) begin
                perr_q <= 1'b1;
            end else if (err_clr) begin
                perr_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/scard_tx.sv
module scard_tx
    import scard_tx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              parity_odd,
    input  logic              irq_on_done,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_in,
    input  logic              irq_clr,
    input  logic              err_clr,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq,
    output logic              perr
);
    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              busy;
    logic              load;
    logic              tick;
    logic              done;
    logic              stop_low;
    tx_frame_t         frame;

    assign load        = !busy && full_q && tx_en;
    assign frame.data  = hold_q;
    assign frame.par   = frame_parity(hold_q, parity_odd);
    assign buf_empty   = !full_q;
    assign shift_empty = !busy && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else if (load) begin
            full_q <= 1'b0;
        end else if (wr_valid && !full_q) begin
            full_q <= 1'b1;
            hold_q <= wr_data;
        end
    end

    scard_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .div_n (div_n),
        .tick  (tick)
    );

    scard_shifter #(.OVS(OVS)) u_shf (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame_in (frame),
        .tick     (tick),
        .line_in  (line_in),
        .txd      (txd),
        .busy     (busy),
        .done     (done),
        .stop_low (stop_low)
    );

    scard_flags u_flg (
        .clk         (clk),
        .rst         (rst),
        .irq_on_done (irq_on_done),
        .load        (load),
        .done        (done),
        .stop_low    (stop_low),
        .irq_clr     (irq_clr),
        .err_clr     (err_clr),
        .irq         (irq),
        .perr        (perr)
    );
endmodule

// File: rtl/scard_tx_chk.sv
module scard_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic irq_on_done,
    input logic wr_valid,
    input logic line_in,
    input logic irq_clr,
    input logic err_clr,
    input logic txd,
    input logic buf_empty,
    input logic shift_empty,
    input logic irq,
    input logic perr
);
    // R5
    txd_low_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !txd |-> !shift_empty);

    // R4
    wr_accept_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && buf_empty |=> !buf_empty);

    // R6
    start_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txd) |-> $past(tx_en));

    // R7
    irq_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) && !$past(irq_on_done) |-> irq);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_clr |=> irq);

    // R10
    perr_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(perr) |-> !$past(line_in));

    // R11
    perr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        perr && !err_clr |=> perr);
endmodule

bind scard_tx scard_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .irq_on_done (irq_on_done),
    .wr_valid    (wr_valid),
    .line_in     (line_in),
    .irq_clr     (irq_clr),
    .err_clr     (err_clr),
    .txd         (txd),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .irq         (irq),
    .perr        (perr)
);

// File: tb/scard_tx_test.sv
module scard_tx_test;
    localparam int DIV_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tx_en = 1'b1;
    logic             parity_odd = 1'b0;
    logic             irq_on_done = 1'b0;
    logic [DIV_W-1:0] div_n = 4'd1;
    logic             wr_valid = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic             irq_clr = 1'b0;
    logic             err_clr = 1'b0;
    logic             peer_low = 1'b0;
    logic             line_in;
    logic             txd, buf_empty, shift_empty, irq, perr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [10:0] cap;

    assign line_in = txd & ~peer_low;

    always #2 clk = ~clk;

    scard_tx #(.DIV_W(DIV_W), .OVS(16)) uut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .parity_odd(parity_odd),
        .irq_on_done(irq_on_done), .div_n(div_n), .wr_valid(wr_valid),
        .wr_data(wr_data), .line_in(line_in), .irq_clr(irq_clr),
        .err_clr(err_clr), .txd(txd), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq), .perr(perr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int unit_len();
        return int'(div_n) + 1;
    endfunction

    function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic odd);
        return {1'b1, (^d) ^ odd, d, 1'b0};
    endfunction

    task automatic do_write(input logic [7:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_start();
        for (int i = 0; i < 4000; i++) begin
            if (txd == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            if (shift_empty == 1'b1) break;
            @(negedge clk);
        end
    endtask

    // Samples the middle of every bit; optionally pulls the line low around
    // the middle of bit pull_k (1..10).
    task automatic capture(input int pull_k);
        int u;
        u = unit_len();
        wait_start();
        waitn(8 * u);
        cap[0] = txd;
        for (int k = 1; k < 11; k++) begin
            if (k == pull_k) begin
                waitn(12 * u);
                peer_low = 1'b1;
                waitn(4 * u);
                cap[k] = txd;
                waitn(4 * u);
                peer_low = 1'b0;
            end else begin
                waitn(16 * u);
                cap[k] = txd;
            end
        end
    endtask

    task automatic t_reset();
        check("R1 txd", txd, 1);
        check("R1 buf_empty", buf_empty, 1);
        check("R1 shift_empty", shift_empty, 1);
        check("R1 irq", irq, 0);
        check("R1 perr", perr, 0);
    endtask

    task automatic t_frame(input logic [7:0] d, input logic odd, input logic [3:0] dv);
        div_n = dv;
        parity_odd = odd;
        do_write(d);
        check("R4 buf_empty after write", buf_empty, 0);
        wait_start();
        check("R4 buf_empty at start bit", buf_empty, 1);
        check("R5 shift_empty during frame", shift_empty, 0);
        capture(0);
        check(odd ? "R3 odd parity frame" : "R2 R3 even parity frame", cap, exp_frame(d, odd));
        wait_idle();
        waitn(2);
        check("R5 shift_empty after frame", shift_empty, 1);
        check("R2 txd idle high", txd, 1);
    endtask

    task automatic t_bitlen(input logic [3:0] dv);
        int cnt;
        div_n = dv;
        do_write(8'h01);
        wait_start();
        cnt = 0;
        while (txd == 1'b0 && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        check("R2 start bit length", cnt, 16 * (int'(dv) + 1));
        wait_idle();
        waitn(2);
    endtask

    task automatic t_disable();
        int hi;
        div_n = 4'd1;
        parity_odd = 1'b0;
        tx_en = 1'b0;
        do_write(8'h3C);
        hi = 0;
        for (int i = 0; i < 200; i++) begin
            if (txd == 1'b1) hi++;
            @(negedge clk);
        end
        check("R6 txd high while disabled", hi, 200);
        check("R6 byte held", buf_empty, 0);
        do_write(8'hC3);
        tx_en = 1'b1;
        capture(0);
        check("R4 R6 held byte sent, second write dropped", cap, exp_frame(8'h3C, 1'b0));
        wait_idle();
        waitn(2);
        check("R4 dropped write left nothing pending", buf_empty, 1);
    endtask

    task automatic t_irq_sel0();
        irq_on_done = 1'b0;
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R9 irq cleared", irq, 0);
        do_write(8'h5A);
        wait_start();
        check("R7 irq at buffer empty", irq, 1);
        waitn(40);
        check("R9 irq held", irq, 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R9 irq clear mid frame", irq, 0);
        wait_idle();
        waitn(4);
        check("R7 no irq at frame end", irq, 0);
    endtask

    task automatic t_irq_sel1();
        irq_on_done = 1'b1;
        do_write(8'h81);
        wait_start();
        check("R8 no irq at load", irq, 0);
        wait_idle();
        waitn(2);
        check("R8 irq at frame end", irq, 1);
        waitn(50);
        check("R9 irq still held", irq, 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R9 irq cleared", irq, 0);
        irq_on_done = 1'b0;
    endtask

    task automatic t_perr();
        div_n = 4'd1;
        do_write(8'h77);
        capture(10);
        wait_idle();
        waitn(2);
        check("R10 low in stop bit sets perr", perr, 1);
        waitn(60);
        check("R11 perr sticky", perr, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        check("R11 perr cleared", perr, 0);
        do_write(8'h12);
        capture(4);
        check("R10 frame intact with data-bit pull", cap, exp_frame(8'h12, 1'b0));
        wait_idle();
        waitn(2);
        check("R10 low in data bit ignored", perr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        waitn(3);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_frame(8'hA5, 1'b0, 4'd1);
        t_frame(8'h6B, 1'b1, 4'd0);
        t_frame(8'h00, 1'b1, 4'd2);
        t_bitlen(4'd2);
        t_bitlen(4'd0);
        t_disable();
        t_irq_sel0();
        t_irq_sel1();
        t_perr();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule